// File: doc/BRIEF.md
# Startup Interrupt Broadcast Sequencer

This block is a small bus master that wakes the secondary cores of a multi-core system. When started, it writes an INIT command into the interrupt command register of the local interrupt controller, addressed to every core except the sender. It then polls that register until the delivery-status bit reads clear. Next it writes a startup command carrying an 8-bit vector and polls again. When the second poll completes, it pulses `done_o`.

The vector is sampled when the sequence is accepted. The block also presents the real-mode entry address that the woken cores will fetch from, which is the vector shifted left by 12 bits. If delivery status stays set for too many consecutive reads, the sequence is abandoned and a sticky error flag is raised.

The bus port is a plain request/acknowledge port. The request, write-enable, address and write data are held until the cycle in which `bus_ack_i` is high. Read data is taken in that same cycle.

Top module: `ipi_startup_seq`

## Requirements
- R1: After reset is asserted, `bus_req_o`, `done_o` and `err_o` are 0.
- R2: A `start_i` seen while idle launches a sequence. Its first transaction is a write of 0x000C4500 (INIT) to address 0xFEE00300. In that value, bits 19:18 = 11 mean all cores except the sender, bits 10:8 = 101 select INIT and bit 14 is the assert level.
- R3: After each command write, the block reads address 0xFEE00300 repeatedly until a read returns bit 12 (delivery status) equal to 0. No other bit of the read data affects the sequence.
- R4: Only after the first poll ends with bit 12 clear does the block write 0x000C4600 OR vector to 0xFEE00300. Bits 10:8 = 110 select the startup command and bits 7:0 hold the vector.
- R5: The vector is captured at the accepted start. Changing `vector_i` later does not alter the startup command.
- R6: From the cycle after an accepted start, `entry_addr_o` equals the captured vector shifted left by 12, zero-extended to 32 bits.
- R7: `done_o` is high for exactly one cycle. That cycle is the one right after the acknowledge of the second-phase read that returned bit 12 clear.
- R8: If POLL_LIMIT consecutive reads in one poll phase return bit 12 set, `err_o` rises and no further transaction is issued. In that case `done_o` stays low. `err_o` holds until the next accepted start, which clears it.
- R9: While a request is pending without acknowledge, its write-enable, address and write data stay unchanged.
- R10: A `start_i` pulse while a sequence runs is ignored: exactly two command writes and one `done_o` pulse result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch request, sampled when idle |
| vector_i | input | 8 | Startup vector |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky poll-timeout flag |
| entry_addr_o | output | 32 | Real-mode entry address derived from the captured vector |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Transaction address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transaction acknowledge |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
A transaction completes in the cycle its acknowledge is sampled, and the next request appears one cycle later. The responder model therefore logs every acknowledged write and read, and the counts and values are compared once the sequence has settled. `done_o` is due exactly one cycle after the acknowledge of the final clean read. The bench stamps that acknowledge with a cycle counter and requires the pulse at stamp plus one. `entry_addr_o` and the clearing of `err_o` are due one cycle after start is accepted, and they are sampled on the next falling edge. Sweeps cover every vector, busy-read counts below, at and above the limit in both phases, and acknowledge latencies of zero to two cycles.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_INIT,
    S_POLL_INIT,
    S_WR_SIPI,
    S_POLL_SIPI,
    S_DONE
  } seq_state_e;

  localparam logic [1:0] SHORT_ALL_BUT_SELF = 2'b11;
  localparam logic [2:0] MODE_INIT          = 3'b101;
  localparam logic [2:0] MODE_STARTUP       = 3'b110;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ipi_cmd_build.sv
module ipi_cmd_build #(
  parameter int VEC_W       = 8,
  parameter int DATA_W      = 32,
  parameter int ENTRY_SHIFT = 12
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              sel_startup_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic [DATA_W-1:0] entry_o
);
  import ipi_pkg::*;

  always_comb begin
    cmd_o        = '0;
    cmd_o[19:18] = SHORT_ALL_BUT_SELF;
    cmd_o[14]    = 1'b1;
    cmd_o[10:8]  = sel_startup_i ? MODE_STARTUP : MODE_INIT;
    if (sel_startup_i) cmd_o[VEC_W-1:0] = vec_i;
  end

  always_comb begin
    entry_o = '0;
    entry_o[ENTRY_SHIFT +: VEC_W] = vec_i;
  end
endmodule

// File: rtl/ipi_poll_timer.sv
module ipi_poll_timer #(
  parameter int POLL_LIMIT = 1024,
  localparam int CNT_W     = $clog2(POLL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic busy_hit_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = busy_hit_i && (cnt_q == CNT_W'(POLL_LIMIT - 1));
  assign cnt_en    = clr_i || (busy_hit_i && !expired_o);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(POLL_LIMIT));
endmodule

// File: rtl/ipi_seq_fsm.sv
module ipi_seq_fsm #(
  parameter int VEC_W    = 8,
  parameter int DATA_W   = 32,
  parameter int BUSY_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  vector_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              expired_i,
  output logic              req_o,
  output logic              we_o,
  output logic              sel_startup_o,
  output logic              busy_hit_o,
  output logic              timer_clr_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              done_o,
  output logic              err_o
);
  import ipi_pkg::*;

  seq_state_e        state_q, state_d;
  logic [VEC_W-1:0]  vec_q;
  logic              err_q;
  logic              accept;
  logic              polling;
  logic              poll_clean;
  logic              err_set;

  assign accept     = (state_q == S_IDLE) && start_i;
  assign polling    = (state_q == S_POLL_INIT) || (state_q == S_POLL_SIPI);
  assign busy_hit_o = polling && ack_i && rdata_i[BUSY_BIT];
  assign poll_clean = polling && ack_i && !rdata_i[BUSY_BIT];
  assign err_set    = busy_hit_o && expired_i;
  assign timer_clr_o = !polling;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (start_i) state_d = S_WR_INIT;
      S_WR_INIT:   if (ack_i)   state_d = S_POLL_INIT;
      S_POLL_INIT: begin
        if (poll_clean)   state_d = S_WR_SIPI;
        else if (err_set) state_d = S_IDLE;
      end
      S_WR_SIPI:   if (ack_i)   state_d = S_POLL_SIPI;
      S_POLL_SIPI: begin
        if (poll_clean)   state_d = S_DONE;
        else if (err_set) state_d = S_IDLE;
      end
      S_DONE:      state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (accept) vec_q <= vector_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (accept)  err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign req_o         = (state_q != S_IDLE) && (state_q != S_DONE);
  assign we_o          = (state_q == S_WR_INIT) || (state_q == S_WR_SIPI);
  assign sel_startup_o = (state_q == S_WR_SIPI);
  assign vec_o         = vec_q;
  assign done_o        = (state_q == S_DONE);
  assign err_o         = err_q;

  assert_err_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !start_i) |=> $stable(err_q));

  assert_vec_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(vec_q));
endmodule

// File: rtl/ipi_startup_seq.sv
module ipi_startup_seq #(
  parameter int          VEC_W       = 8,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 32,
  parameter int          BUSY_BIT    = 12,
  parameter int          ENTRY_SHIFT = 12,
  parameter int          POLL_LIMIT  = 1024,
  parameter logic [31:0] CMD_ADDR    = 32'hFEE0_0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  vector_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] entry_addr_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  logic             rst_sync_n;
  logic             sel_startup;
  logic             busy_hit;
  logic             timer_clr;
  logic             expired;
  logic [VEC_W-1:0] vec_q;

  ipi_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipi_seq_fsm #(
    .VEC_W    (VEC_W),
    .DATA_W   (DATA_W),
    .BUSY_BIT (BUSY_BIT)
  ) i_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start_i       (start_i),
    .vector_i      (vector_i),
    .ack_i         (bus_ack_i),
    .rdata_i       (bus_rdata_i),
    .expired_i     (expired),
    .req_o         (bus_req_o),
    .we_o          (bus_we_o),
    .sel_startup_o (sel_startup),
    .busy_hit_o    (busy_hit),
    .timer_clr_o   (timer_clr),
    .vec_o         (vec_q),
    .done_o        (done_o),
    .err_o         (err_o)
  );

  ipi_poll_timer #(
    .POLL_LIMIT (POLL_LIMIT)
  ) i_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (timer_clr),
    .busy_hit_i (busy_hit),
    .expired_o  (expired)
  );

  ipi_cmd_build #(
    .VEC_W       (VEC_W),
    .DATA_W      (DATA_W),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) i_cmd (
    .vec_i         (vec_q),
    .sel_startup_i (sel_startup),
    .cmd_o         (bus_wdata_o),
    .entry_o       (entry_addr_o)
  );

  assign bus_addr_o = CMD_ADDR[ADDR_W-1:0];

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) &&
                                   $stable(bus_addr_o) && $stable(bus_wdata_o)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  assert_done_no_err_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !err_o);

  assert_done_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !bus_req_o);
endmodule

// File: tb/test_ipi_startup_seq.sv
module test_ipi_startup_seq;
  localparam int LIMIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  vector_i = '0;
  logic        done_o, err_o;
  logic [31:0] entry_addr_o;
  logic        bus_req_o, bus_we_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // responder model state
  int          lat = 0;
  int          busy1 = 0, busy2 = 0;
  int          wcount = 0, rd1 = 0, rd2 = 0;
  int          addr_bad = 0, hold_bad = 0;
  logic [31:0] wlog [0:3];
  int          last_ack_cyc = 0;

  ipi_startup_seq #(.POLL_LIMIT(LIMIT)) i_ipi_startup_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .vector_i     (vector_i),
    .done_o       (done_o),
    .err_o        (err_o),
    .entry_addr_o (entry_addr_o),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_ack_i    (bus_ack_i),
    .bus_rdata_i  (bus_rdata_i)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // bus responder
  initial begin
    int          wait_n;
    logic [31:0] first_wd;
    logic        first_we;
    wait_n = 0;
    first_wd = '0;
    first_we = 1'b0;
    forever begin
      @(negedge clk);
      if (bus_ack_i) begin
        bus_ack_i = 1'b0;
        wait_n = 0;
      end else if (bus_req_o) begin
        if (wait_n == 0) begin
          first_wd = bus_wdata_o;
          first_we = bus_we_o;
        end else if (first_wd !== bus_wdata_o || first_we !== bus_we_o) begin
          hold_bad++;
        end
        if (bus_addr_o !== 32'hFEE0_0300) addr_bad++;
        if (wait_n < lat) begin
          wait_n++;
        end else begin
          bus_ack_i = 1'b1;
          last_ack_cyc = cyc;
          if (bus_we_o) begin
            if (wcount < 4) wlog[wcount] = bus_wdata_o;
            wcount++;
            bus_rdata_i = '0;
          end else if (wcount <= 1) begin
            rd1++;
            bus_rdata_i = 32'h0000_A800 | ((busy1 > 0) ? 32'h1000 : 32'h0);
            if (busy1 > 0) busy1--;
          end else begin
            rd2++;
            bus_rdata_i = 32'h0000_A800 | ((busy2 > 0) ? 32'h1000 : 32'h0);
            if (busy2 > 0) busy2--;
          end
        end
      end
    end
  end

  task automatic run_seq(input logic [7:0] vec, input int b1, input int b2,
                         input int l, input bit vchg, input bit glitch);
    int  dones, done_at, settle, exp_w, exp_r1, exp_r2;
    bit  finished, exp_err;
    lat = l; busy1 = b1; busy2 = b2;
    wcount = 0; rd1 = 0; rd2 = 0; addr_bad = 0; hold_bad = 0;
    dones = 0; done_at = -1; finished = 0; settle = 0;
    @(negedge clk);
    start_i = 1'b1;
    vector_i = vec;
    @(negedge clk);
    start_i = 1'b0;
    if (vchg) vector_i = ~vec;
    check(err_o === 1'b0, "R8 err cleared by start", err_o, 0);
    check(entry_addr_o === {12'h0, vec, 12'h000}, "R6 entry address", entry_addr_o,
          {12'h0, vec, 12'h000});
    for (int i = 0; i < 400; i++) begin
      if (done_o) begin dones++; done_at = cyc; finished = 1; end
      if (err_o) finished = 1;
      if (finished) settle++;
      if (settle > 6) break;
      @(negedge clk);
      if (glitch && i == 1) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    exp_err = (b1 >= LIMIT) || (b2 >= LIMIT);
    exp_w   = (b1 >= LIMIT) ? 1 : 2;
    exp_r1  = (b1 >= LIMIT) ? LIMIT : b1 + 1;
    exp_r2  = (b1 >= LIMIT) ? 0 : ((b2 >= LIMIT) ? LIMIT : b2 + 1);
    check(err_o === exp_err, "R8 error flag", err_o, exp_err);
    check(wcount == exp_w, glitch ? "R10 write count" : "R8 write count", wcount, exp_w);
    check(wlog[0] === 32'h000C_4500, "R2 INIT command", wlog[0], 32'h000C_4500);
    if (exp_w == 2)
      check(wlog[1] === (32'h000C_4600 | vec), vchg ? "R5 captured vector" : "R4 startup command",
            wlog[1], 32'h000C_4600 | vec);
    check(rd1 == exp_r1, "R3 first poll reads", rd1, exp_r1);
    check(rd2 == exp_r2, "R3 second poll reads", rd2, exp_r2);
    check(dones == (exp_err ? 0 : 1), glitch ? "R10 done count" : "R7 done count",
          dones, exp_err ? 0 : 1);
    if (!exp_err)
      check(done_at == last_ack_cyc + 1, "R7 done timing", done_at, last_ack_cyc + 1);
    check(addr_bad == 0, "R2 address", addr_bad, 0);
    check(hold_bad == 0, "R9 request held", hold_bad, 0);
    check(entry_addr_o === {12'h0, vec, 12'h000}, "R6 entry address held", entry_addr_o,
          {12'h0, vec, 12'h000});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_req_o === 1'b0, "R1 reset req", bus_req_o, 0);
    check(done_o === 1'b0, "R1 reset done", done_o, 0);
    check(err_o === 1'b0, "R1 reset err", err_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bus_req_o === 1'b0, "R1 idle after reset", bus_req_o, 0);
    for (int v = 0; v < 256; v++) run_seq(8'(v), 0, 0, v % 3, v[0], v[1] & v[2]);
    for (int l = 0; l < 3; l++)
      for (int b1 = 0; b1 < 6; b1++)
        for (int b2 = 0; b2 < 6; b2++)
          run_seq(8'(b1 * 37 + b2 * 11 + l), b1, b2, l, (b1 + b2) % 2 == 1, b2 == 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule